// File: doc/BRIEF.md
# Highest-Level Channel Merger

This block combines several time-multiplexed level streams into a single multiplexed stream. Every source owns a write port and a private dual-port level bank that holds one level per channel number. A source may rewrite any channel at any moment. A scan engine steps through the channel numbers in ascending order. For each channel it reads the level from every bank, keeps the largest, and presents it with the channel number and a one-cycle valid strobe.

The banks are written only on the rising clock edge and read only on the falling edge. A read and a write therefore never address a bank entry in the same instant, and no read can return a value caught half-way through a write.

After reset the engine runs a clearing sweep that zeroes every bank entry. It then scans without stopping, one channel per clock cycle, and wraps from the last channel back to channel 0. The controller has two states, ST_CLEAR and ST_SCAN. The only transition is T_SWEEP_DONE, from ST_CLEAR to ST_SCAN, taken on the rising edge that writes the last channel of the sweep. ST_SCAN has no exit other than reset.

Top module: `level_merge`

## Requirements
- R1: When `wr_en[s]` is high on a rising edge while scanning, bank `s` stores `wr_level[s*LEVEL_W +: LEVEL_W]` at channel `wr_chan[s*CHAN_W +: CHAN_W]`.
- R2: The emitted `out_level` for a channel is the largest level held for that channel across all sources. When several sources share the maximum, that value is emitted unchanged.
- R3: Once scanning, `out_valid` is high on every cycle. `out_chan` rises by one each cycle and wraps from NUM_CHANNELS-1 to 0.
- R4: While `rst_n` is low, and during the clearing sweep, `out_valid` is low. The first valid output carries channel 0 and appears on the (NUM_CHANNELS+1)-th rising edge after reset release, counting the first edge with `rst_n` high as edge 1.
- R5: After reset every bank entry holds zero, so a channel that no source has written is emitted as zero.
- R6: Source writes presented during the clearing sweep (rising edges 1 to NUM_CHANNELS after release) are discarded.
- R7: A write is committed on a rising edge and a channel is read on the following falling edge. A write committed on the edge just before the read of its channel appears in that channel's next output. A write committed on the same edge as that output appears only in the following scan.
- R8: A write on one source's port leaves the entries of every other source's bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Bank writes happen on the rising edge, bank reads on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NUM_SOURCES | Per-source write strobe |
| wr_chan | input | NUM_SOURCES*CHAN_W | Per-source channel index, packed by source |
| wr_level | input | NUM_SOURCES*LEVEL_W | Per-source level, packed by source |
| out_valid | output | 1 | Merged level valid |
| out_chan | output | CHAN_W | Channel number of the merged level |
| out_level | output | LEVEL_W | Highest level for that channel |

## Verification
The hardest case is a write that lands on the very channel the scan is about to read, or is emitting, in that same cycle. Random writes almost never hit that window.

The bench keeps its own count of rising edges since reset release. From that count it derives which channel is read on each falling edge. It then times directed writes to commit exactly one edge before the read of a chosen channel, and exactly on the edge that emits it.

A random phase adds to this. Its writes cluster within a few channels ahead of the scan position on every source, so many of them fall close to the read and emit edges. A model that applies writes in rising-edge order predicts every emitted level.

// File: rtl/lvlmerge_pkg.sv
package lvlmerge_pkg;

    // Controller states: sweep-zero the banks, then scan forever
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_SCAN  = 1'b1
    } merge_state_e;

endpackage

// File: rtl/lvlmerge_bank.sv
// One source's level bank: written on the rising edge, read on the falling edge.
module lvlmerge_bank #(
    parameter  int DEPTH = 512,
    parameter  int LVL_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LVL_W-1:0] rd_lvl
);

    logic [LVL_W-1:0] store [DEPTH];

    // write phase: rising edge only
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_lvl;
        end
    end

    // read phase: falling edge only
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_lvl <= '0;
        end else if (rd_en) begin
            rd_lvl <= store[rd_idx];
        end
    end

    AST_BANK_IDLE_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_lvl)) else $error("bank read changed outside read phase"); // R7

endmodule

// File: rtl/lvlmerge_maxtree.sv
// Chain of comparators that keeps the largest level across all sources.
module lvlmerge_maxtree #(
    parameter int N_SRC = 4,
    parameter int LVL_W = 8
) (
    input  logic                   valid_i,
    input  logic [N_SRC*LVL_W-1:0] lvls_i,
    output logic [LVL_W-1:0]       max_o
);

    logic [LVL_W-1:0] stage [N_SRC];

    assign stage[0] = lvls_i[0 +: LVL_W];

    for (genvar g = 1; g < N_SRC; g++) begin : g_stage
        logic [LVL_W-1:0] cand;
        assign cand     = lvls_i[g*LVL_W +: LVL_W];
        assign stage[g] = (cand > stage[g-1]) ? cand : stage[g-1];
    end

    assign max_o = stage[N_SRC-1];

    // the winner dominates every input and is one of them (ties pass through)
    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (valid_i) begin
                AST_MAX_DOMINATES: assert (max_o >= lvls_i[i*LVL_W +: LVL_W])
                    else $error("merged level below an input"); // R2
            end
            if (max_o == lvls_i[i*LVL_W +: LVL_W]) begin
                hit = 1'b1;
            end
        end
        if (valid_i) begin
            AST_MAX_IS_MEMBER: assert (hit) else $error("merged level not from any source"); // R2
        end
    end

endmodule

// File: rtl/lvlmerge_scan_fsm.sv
// Controller: clearing sweep, then an endless ascending channel scan.
module lvlmerge_scan_fsm
    import lvlmerge_pkg::*;
#(
    parameter  int N_CHAN = 512,
    localparam int IDX_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clearing_o,
    output logic             scanning_o,
    output logic [IDX_W-1:0] chan_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHAN - 1);

    merge_state_e     state_q, state_d;
    logic [IDX_W-1:0] chan_q, chan_d;
    logic             at_last;

    assign at_last = (chan_q == LAST_IDX);

    // next state and counter
    always_comb begin
        state_d = state_q;
        chan_d  = at_last ? '0 : chan_q + 1'b1;
        unique case (state_q)
            ST_CLEAR: if (at_last) state_d = ST_SCAN;   // T_SWEEP_DONE
            ST_SCAN:  state_d = ST_SCAN;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // outputs
    always_comb begin
        clearing_o = 1'b0;
        scanning_o = 1'b0;
        unique case (state_q)
            ST_CLEAR: clearing_o = 1'b1;
            ST_SCAN:  scanning_o = 1'b1;
            default:  clearing_o = 1'b1;
        endcase
        chan_o = chan_q;
    end

    AST_SCAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        scanning_o |=> scanning_o) else $error("left scan state"); // R3

    AST_SWEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scanning_o) |-> (chan_o == '0)) else $error("scan did not begin at channel 0"); // R4

endmodule

// File: rtl/level_merge.sv
// Highest-level merger: per-source banks, split-phase access, sequential max scan.
module level_merge
    import lvlmerge_pkg::*;
#(
    parameter  int NUM_SOURCES  = 4,
    parameter  int NUM_CHANNELS = 512,
    parameter  int LEVEL_W      = 8,
    localparam int CHAN_W       = (NUM_CHANNELS > 1) ? $clog2(NUM_CHANNELS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SOURCES-1:0]        wr_en,
    input  logic [NUM_SOURCES*CHAN_W-1:0] wr_chan,
    input  logic [NUM_SOURCES*LEVEL_W-1:0] wr_level,
    output logic                          out_valid,
    output logic [CHAN_W-1:0]             out_chan,
    output logic [LEVEL_W-1:0]            out_level
);

    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(NUM_CHANNELS - 1);

    logic                           clearing, scanning;
    logic [CHAN_W-1:0]              cur_chan;
    logic [NUM_SOURCES*LEVEL_W-1:0] bank_lvls;
    logic                           rd_vld_q;
    logic [CHAN_W-1:0]              rd_chan_q;
    logic [LEVEL_W-1:0]             max_lvl;

    lvlmerge_scan_fsm #(.N_CHAN(NUM_CHANNELS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clearing_o (clearing),
        .scanning_o (scanning),
        .chan_o     (cur_chan)
    );

    for (genvar s = 0; s < NUM_SOURCES; s++) begin : g_src
        logic               b_wr_en;
        logic [CHAN_W-1:0]  b_wr_idx;
        logic [LEVEL_W-1:0] b_wr_lvl;

        // sweep owns the write port while clearing; source writes are dropped then
        always_comb begin
            if (clearing) begin
                b_wr_en  = 1'b1;
                b_wr_idx = cur_chan;
                b_wr_lvl = '0;
            end else begin
                b_wr_en  = wr_en[s];
                b_wr_idx = wr_chan[s*CHAN_W +: CHAN_W];
                b_wr_lvl = wr_level[s*LEVEL_W +: LEVEL_W];
            end
        end

        lvlmerge_bank #(.DEPTH(NUM_CHANNELS), .LVL_W(LEVEL_W)) i_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (b_wr_en),
            .wr_idx (b_wr_idx),
            .wr_lvl (b_wr_lvl),
            .rd_en  (scanning),
            .rd_idx (cur_chan),
            .rd_lvl (bank_lvls[s*LEVEL_W +: LEVEL_W])
        );
    end

    // read-phase tag, captured alongside the bank reads
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_chan_q <= '0;
        end else begin
            rd_vld_q  <= scanning;
            rd_chan_q <= cur_chan;
        end
    end

    lvlmerge_maxtree #(.N_SRC(NUM_SOURCES), .LVL_W(LEVEL_W)) i_max (
        .valid_i (rd_vld_q),
        .lvls_i  (bank_lvls),
        .max_o   (max_lvl)
    );

    // output register, rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_level <= '0;
        end else begin
            out_valid <= rd_vld_q;
            out_chan  <= rd_chan_q;
            out_level <= max_lvl;
        end
    end

    AST_QUIET_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |=> !out_valid) else $error("output during sweep"); // R4

    AST_NO_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_valid) |-> out_valid) else $error("missing output cycle"); // R3

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |->
            (out_chan == (($past(out_chan) == LAST_CHAN) ? '0 : $past(out_chan) + 1'b1)))
        else $error("channel order broken"); // R3

endmodule

// File: tb/test_level_merge.sv
`timescale 1ns/1ps
module test_level_merge;

    localparam int NS = 4;
    localparam int NC = 512;
    localparam int LW = 8;
    localparam int CW = $clog2(NC);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      wr_en = '0;
    logic [NS*CW-1:0]   wr_chan = '0;
    logic [NS*LW-1:0]   wr_level = '0;
    logic               out_valid;
    logic [CW-1:0]      out_chan;
    logic [LW-1:0]      out_level;

    int n_vec = 0;
    int n_bad = 0;
    int edge_idx = 0;
    bit seen_first = 1'b0;
    int wraps = 0;

    logic [LW-1:0]    mdl [NS][NC];
    logic [CW+LW-1:0] exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    level_merge #(.NUM_SOURCES(NS), .NUM_CHANNELS(NC), .LEVEL_W(LW)) i_level_merge (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_level(wr_level),
        .out_valid(out_valid), .out_chan(out_chan), .out_level(out_level)
    );

    function automatic logic [LW-1:0] model_max(int c);
        logic [LW-1:0] m = '0;
        for (int s = 0; s < NS; s++) if (mdl[s][c] > m) m = mdl[s][c];
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // model of the banks: writes land on rising edges after the sweep (R1, R6, R8)
    always @(posedge clk) begin
        if (!rst_n) edge_idx = 0;
        else begin
            edge_idx = edge_idx + 1;
            if (edge_idx > NC) begin
                for (int s = 0; s < NS; s++)
                    if (wr_en[s]) mdl[s][int'(wr_chan[s*CW +: CW])] = wr_level[s*LW +: LW];
            end
        end
    end

    // predictor: the channel read on this falling edge and its expected maximum
    always @(negedge clk) begin
        if (rst_n && edge_idx >= NC) begin
            int c;
            c = (edge_idx - NC) % NC;
            exp_q.push_back({CW'(c), model_max(c)});
        end
    end

    // monitor: compares each produced item against the queue
    always @(posedge clk) begin
        #3;
        if (exp_q.size() == 0) begin
            check(out_valid == 1'b0, "R4 out_valid idle", out_valid, 0);
        end else begin
            logic [CW+LW-1:0] it;
            it = exp_q.pop_front();
            check(out_valid == 1'b1, "R3 out_valid", out_valid, 1);
            if (out_valid) begin
                if (!seen_first) begin
                    seen_first = 1'b1;
                    check(edge_idx == NC + 1, "R4 first output edge", edge_idx, NC + 1);
                    check(out_chan == '0, "R4 first channel", out_chan, 0);
                end
                check(out_chan == it[LW +: CW], "R3 out_chan", out_chan, it[LW +: CW]);
                check(out_level == it[LW-1:0], "R2 out_level", out_level, it[LW-1:0]);
                if (out_chan == '0 && edge_idx > NC + 1) wraps++;
            end
        end
    end

    // all main-thread tasks start and end at rising edge + 5 ns
    task automatic wr1(input int s, input int c, input int l);
        wr_en[s] = 1'b1;
        wr_chan[s*CW +: CW] = CW'(c);
        wr_level[s*LW +: LW] = LW'(l);
        @(posedge clk); #5;
        wr_en = '0;
    endtask

    task automatic expect_chan(input int c, input int l, input string req);
        int guard = 0;
        forever begin
            @(posedge clk); #3;
            if (out_valid && out_chan == CW'(c)) break;
            guard++;
            if (guard > 2 * NC) break;
        end
        check(out_valid && out_chan == CW'(c), req, out_chan, c);
        check(out_level == LW'(l), req, out_level, l);
        #2;
    endtask

    // commit on the edge just before the channel's read (R7)
    task automatic write_at_read(input int s, input int c, input int l);
        while (((edge_idx + 1 - NC) % NC) != c) begin @(posedge clk); #5; end
        wr1(s, c, l);
        expect_chan(c, l, "R7 write before read");
    endtask

    // commit on the same edge that emits the channel (R7)
    task automatic write_at_emit(input int s, input int c, input int l, input int old_l);
        while (((edge_idx - NC) % NC) != c) begin @(posedge clk); #5; end
        wr1(s, c, l);
        check(out_valid && out_chan == CW'(c), "R7 emit edge chan", out_chan, c);
        check(out_level == LW'(old_l), "R7 emit edge old level", out_level, old_l);
        expect_chan(c, l, "R7 next scan new level");
    endtask

    initial begin
        for (int s = 0; s < NS; s++) for (int c = 0; c < NC; c++) mdl[s][c] = '0;
        repeat (3) @(posedge clk);
        #5;
        check(out_valid == 1'b0, "R4 reset valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        #5;
        wr1(1, 5, 'hAA);                       // R6: dropped during sweep
        wr1(2, 9, 'h33);                       // R6
        while (edge_idx < NC + 1) begin @(posedge clk); #5; end
        // R2 distinct levels and ties; R8 independence; R1 single store
        wr_en = '1;
        for (int s = 0; s < NS; s++) begin
            wr_chan[s*CW +: CW] = CW'(10);
            wr_level[s*LW +: LW] = LW'((s == 1) ? 9 : (s == 2) ? 5 : (s == 0) ? 3 : 1);
        end
        @(posedge clk); #5;
        for (int s = 0; s < NS; s++) begin
            wr_chan[s*CW +: CW] = CW'(11);
            wr_level[s*LW +: LW] = 8'h40;
        end
        @(posedge clk); #5;
        for (int s = 0; s < NS; s++) begin
            wr_chan[s*CW +: CW] = CW'(12);
            wr_level[s*LW +: LW] = (s == 0 || s == 3) ? 8'hFF : 8'h10;
        end
        @(posedge clk); #5;
        wr_en = '0;
        wr1(2, 20, 'h30);
        wr1(0, 20, 'h10);
        wr1(3, 30, 'h77);
        expect_chan(5, 0, "R6 sweep write dropped");
        expect_chan(7, 0, "R5 untouched zero");
        expect_chan(9, 0, "R6 sweep write dropped");
        expect_chan(10, 9, "R2 max of distinct");
        expect_chan(11, 'h40, "R2 all tie");
        expect_chan(12, 'hFF, "R2 partial tie");
        expect_chan(20, 'h30, "R8 other source kept");
        expect_chan(30, 'h77, "R1 stored level");
        write_at_read(0, 200, 'h5A);
        write_at_emit(1, 300, 'h66, 0);
        // random phase clustered just ahead of the scan position
        for (int k = 0; k < 1600; k++) begin
            for (int s = 0; s < NS; s++) begin
                wr_en[s] = ($urandom % 2) == 1;
                wr_chan[s*CW +: CW] = CW'((edge_idx + 1 - NC + int'($urandom_range(0, 3))) % NC);
                wr_level[s*LW +: LW] = LW'($urandom);
            end
            @(posedge clk); #5;
        end
        wr_en = '0;
        repeat (4) @(posedge clk);
        #5;
        check(wraps > 0, "R3 wrap to channel 0", wraps, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule